// File: doc/BRIEF.md
# Ethernet PHY Loopback Path Controller

This block is the digital routing stage of a 10/100 Ethernet transceiver. It sits between the MAC-facing nibble interface and the line-facing nibble streams, and it steers data along one of three paths. In normal operation, MAC transmit nibbles go out toward the line and line receive nibbles go up to the MAC. In near-end loopback, the MAC's own transmit nibbles come back on the MAC receive outputs and the line transmitter is switched off. In far loopback, nibbles received from the link partner are sent straight back out on the line transmit path, and the MAC side is isolated.

Every path goes through the same two-stage register pipeline, so data and valid stay aligned with a fixed two-clock latency. A three-state controller (NORMAL, NEAR, FAR) picks the active path. It moves to a newly requested path only at a frame boundary: both valid inputs must be low and both pipelines must be empty, so no frame is ever cut short. The transitions are NORMAL to NEAR, NORMAL to FAR, NEAR to NORMAL, NEAR to FAR, FAR to NORMAL and FAR to NEAR. Each one is taken when the requested path differs from the current one and the boundary condition holds.

Top module: `phy_loopback_ctrl`

## Requirements
- R1: While reset is applied and after it is released with idle inputs, the block is in NORMAL. `mac_rxd`, `mac_rxdv`, `mac_crs`, `mac_col`, `line_txd` and `line_txdv` are all 0, and `line_tx_on` is 1.
- R2: In NORMAL, `mac_txd`/`mac_txen` appear on `line_txd`/`line_txdv` two clocks later, and `line_tx_on` is 1. `line_rxd`/`line_rxdv` appear two clocks later on `mac_rxd`/`mac_rxdv`, and `mac_crs` equals that delayed `line_rxdv`.
- R3: In NORMAL, `mac_col` is 1 exactly when both the two-clock-delayed `mac_txen` and the two-clock-delayed `line_rxdv` are 1.
- R4: The requested path is NEAR whenever `cfg_near_lb` is 1. In NEAR, `mac_txd`/`mac_txen` return two clocks later on `mac_rxd`/`mac_rxdv`, and `mac_crs` equals that looped-back valid.
- R5: In NEAR, `line_tx_on` and `line_txdv` are 0 and `line_txd` is 0, whatever `mac_txen` does.
- R6: In NEAR, `mac_col` is 0 while `cfg_col_test` is 0. While `cfg_col_test` is 1, `mac_col` equals `mac_txen` delayed by one clock.
- R7: The requested path is FAR when `cfg_far_lb` and `cfg_rmii` are both 1 and `cfg_near_lb` is 0. In FAR, `line_rxd`/`line_rxdv` go out on `line_txd`/`line_txdv` two clocks later, and `line_tx_on` is 1.
- R8: When `cfg_rmii` is 0, `cfg_far_lb` has no effect and the block behaves as in R2 and R3.
- R9: In FAR, `mac_rxd` is 0 and `mac_rxdv`, `mac_crs` and `mac_col` are 0. The `mac_txd`/`mac_txen` inputs have no effect on any output.
- R10: When both `cfg_near_lb` and `cfg_far_lb` are 1, NEAR is used.
- R11: A change of the requested path takes effect only on a clock edge where `mac_txen` and `line_rxdv` are 0 and no valid nibble remains in either pipeline. A frame in progress finishes on the old path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mac_txd | input | 4 | Transmit nibble from MAC |
| mac_txen | input | 1 | Transmit enable from MAC |
| line_rxd | input | 4 | Receive nibble from line side |
| line_rxdv | input | 1 | Receive valid from line side |
| cfg_near_lb | input | 1 | Request near-end loopback |
| cfg_col_test | input | 1 | Collision test enable |
| cfg_far_lb | input | 1 | Request far loopback |
| cfg_rmii | input | 1 | Reduced-pin MAC interface mode active |
| mac_rxd | output | 4 | Receive nibble to MAC |
| mac_rxdv | output | 1 | Receive data valid to MAC |
| mac_crs | output | 1 | Carrier sense to MAC |
| mac_col | output | 1 | Collision to MAC |
| line_txd | output | 4 | Transmit nibble toward line |
| line_txdv | output | 1 | Transmit valid toward line |
| line_tx_on | output | 1 | Line transmitter enable |

## Verification
The latency properties assume that the current path has been held for at least two clocks. They therefore say nothing about the two cycles right after a path change. The boundary properties assume that the control inputs are free of X. The stimulus changes the control bits only between bursts and then drives idle inputs for several clocks until the pipelines drain. The one exception is a deliberate mid-frame change, which the frame-boundary rule is meant to absorb. Inside each path, the sweep steps through every combination of transmit nibble, transmit enable, receive nibble and receive valid.

// File: rtl/phy_lb_pkg.sv
package phy_lb_pkg;

    typedef enum logic [1:0] {
        LB_NORMAL = 2'd0,
        LB_NEAR   = 2'd1,
        LB_FAR    = 2'd2
    } lb_mode_e;

endpackage

// File: rtl/lb_nibble_pipe.sv
module lb_nibble_pipe #(
    parameter int W     = 4,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         vin,
    output logic [W-1:0] dout,
    output logic         vout,
    output logic         busy
);
    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0][W-1:0] d_q;
    logic [DEPTH-1:0]        v_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    d_q[g] <= '0;
                    v_q[g] <= 1'b0;
                end else begin
                    d_q[g] <= din;
                    v_q[g] <= vin;
                end
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    d_q[g] <= '0;
                    v_q[g] <= 1'b0;
                end else begin
                    d_q[g] <= d_q[g-1];
                    v_q[g] <= v_q[g-1];
                end
            end
        end
    end

    assign dout = d_q[LAST];
    assign vout = v_q[LAST];
    assign busy = |v_q;
endmodule

// File: rtl/lb_mode_fsm.sv
module lb_mode_fsm
    import phy_lb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     want_near,
    input  logic     want_far,
    input  logic     rmii_on,
    input  logic     frame_gap,
    output lb_mode_e mode
);
    lb_mode_e state_q;
    lb_mode_e state_d;
    lb_mode_e wanted;

    always_comb begin
        if (want_near)
            wanted = LB_NEAR;
        else if (want_far && rmii_on)
            wanted = LB_FAR;
        else
            wanted = LB_NORMAL;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LB_NORMAL: begin
                if (frame_gap && wanted == LB_NEAR)     state_d = LB_NEAR;
                else if (frame_gap && wanted == LB_FAR) state_d = LB_FAR;
            end
            LB_NEAR: begin
                if (frame_gap && wanted == LB_NORMAL)   state_d = LB_NORMAL;
                else if (frame_gap && wanted == LB_FAR) state_d = LB_FAR;
            end
            LB_FAR: begin
                if (frame_gap && wanted == LB_NORMAL)    state_d = LB_NORMAL;
                else if (frame_gap && wanted == LB_NEAR) state_d = LB_NEAR;
            end
            default: state_d = LB_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LB_NORMAL;
        else        state_q <= state_d;
    end

    assign mode = state_q;
endmodule

// File: rtl/lb_route_out.sv
module lb_route_out
    import phy_lb_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  lb_mode_e     mode,
    input  logic         col_test,
    input  logic         txen_now,
    input  logic [W-1:0] tx_d,
    input  logic         tx_v,
    input  logic [W-1:0] rx_d,
    input  logic         rx_v,
    output logic [W-1:0] mac_rxd,
    output logic         mac_rxdv,
    output logic         mac_crs,
    output logic         mac_col,
    output logic [W-1:0] line_txd,
    output logic         line_txdv,
    output logic         line_tx_on
);
    logic txen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) txen_q <= 1'b0;
        else        txen_q <= txen_now;
    end

    always_comb begin
        mac_rxd    = '0;
        mac_rxdv   = 1'b0;
        mac_crs    = 1'b0;
        mac_col    = 1'b0;
        line_txd   = '0;
        line_txdv  = 1'b0;
        line_tx_on = 1'b0;
        unique case (mode)
            LB_NORMAL: begin
                line_txd   = tx_d;
                line_txdv  = tx_v;
                line_tx_on = 1'b1;
                mac_rxd    = rx_d;
                mac_rxdv   = rx_v;
                mac_crs    = rx_v;
                mac_col    = tx_v & rx_v;
            end
            LB_NEAR: begin
                mac_rxd  = tx_d;
                mac_rxdv = tx_v;
                mac_crs  = tx_v;
                mac_col  = col_test & txen_q;
            end
            LB_FAR: begin
                line_txd   = rx_d;
                line_txdv  = rx_v;
                line_tx_on = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/phy_loopback_ctrl.sv
module phy_loopback_ctrl
    import phy_lb_pkg::*;
#(
    parameter int NIB_W   = 4,
    parameter int PIPE_LEN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] mac_txd,
    input  logic             mac_txen,
    input  logic [NIB_W-1:0] line_rxd,
    input  logic             line_rxdv,
    input  logic             cfg_near_lb,
    input  logic             cfg_col_test,
    input  logic             cfg_far_lb,
    input  logic             cfg_rmii,
    output logic [NIB_W-1:0] mac_rxd,
    output logic             mac_rxdv,
    output logic             mac_crs,
    output logic             mac_col,
    output logic [NIB_W-1:0] line_txd,
    output logic             line_txdv,
    output logic             line_tx_on
);
    logic [NIB_W-1:0] tx_d, rx_d;
    logic             tx_v, rx_v, tx_busy, rx_busy, frame_gap;
    lb_mode_e         cur_mode;

    lb_nibble_pipe #(.W(NIB_W), .DEPTH(PIPE_LEN)) u_tx_pipe (
        .clk(clk), .rst_n(rst_n), .din(mac_txd), .vin(mac_txen),
        .dout(tx_d), .vout(tx_v), .busy(tx_busy)
    );

    lb_nibble_pipe #(.W(NIB_W), .DEPTH(PIPE_LEN)) u_rx_pipe (
        .clk(clk), .rst_n(rst_n), .din(line_rxd), .vin(line_rxdv),
        .dout(rx_d), .vout(rx_v), .busy(rx_busy)
    );

    assign frame_gap = !mac_txen && !line_rxdv && !tx_busy && !rx_busy;

    lb_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .want_near(cfg_near_lb), .want_far(cfg_far_lb),
        .rmii_on(cfg_rmii), .frame_gap(frame_gap), .mode(cur_mode)
    );

    lb_route_out #(.W(NIB_W)) u_route (
        .clk(clk), .rst_n(rst_n), .mode(cur_mode), .col_test(cfg_col_test),
        .txen_now(mac_txen), .tx_d(tx_d), .tx_v(tx_v), .rx_d(rx_d), .rx_v(rx_v),
        .mac_rxd(mac_rxd), .mac_rxdv(mac_rxdv), .mac_crs(mac_crs), .mac_col(mac_col),
        .line_txd(line_txd), .line_txdv(line_txdv), .line_tx_on(line_tx_on)
    );
endmodule

// File: rtl/phy_lb_checker.sv
module phy_lb_checker
    import phy_lb_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input lb_mode_e         cur_mode,
    input logic [NIB_W-1:0] mac_txd,
    input logic             mac_txen,
    input logic [NIB_W-1:0] line_rxd,
    input logic             line_rxdv,
    input logic             cfg_near_lb,
    input logic             cfg_col_test,
    input logic             cfg_far_lb,
    input logic             cfg_rmii,
    input logic [NIB_W-1:0] mac_rxd,
    input logic             mac_rxdv,
    input logic             mac_crs,
    input logic             mac_col,
    input logic [NIB_W-1:0] line_txd,
    input logic             line_txdv,
    input logic             line_tx_on
);
    assert_normal_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == LB_NORMAL && $past(cur_mode, 2) == LB_NORMAL) |->
        (line_txdv == $past(mac_txen, 2) && mac_rxdv == $past(line_rxdv, 2)));

    assert_normal_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == LB_NORMAL && $past(cur_mode, 2) == LB_NORMAL) |->
        (mac_col == ($past(mac_txen, 2) && $past(line_rxdv, 2))));

    assert_near_loop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == LB_NEAR && $past(cur_mode, 2) == LB_NEAR) |->
        (mac_rxdv == $past(mac_txen, 2) && mac_rxd == $past(mac_txd, 2)));

    assert_near_tx_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == LB_NEAR) |-> (!line_tx_on && !line_txdv));

    assert_near_col_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == LB_NEAR && $past(cur_mode) == LB_NEAR) |->
        (mac_col == (cfg_col_test && $past(mac_txen))));

    assert_far_loop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == LB_FAR && $past(cur_mode, 2) == LB_FAR) |->
        (line_txdv == $past(line_rxdv, 2) && line_txd == $past(line_rxd, 2)));

    assert_far_needs_rmii_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == LB_FAR && $past(cur_mode) != LB_FAR) |->
        $past(cfg_rmii && cfg_far_lb && !cfg_near_lb));

    assert_far_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == LB_FAR) |-> (!mac_rxdv && !mac_crs && !mac_col && mac_rxd == '0));

    assert_near_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != $past(cur_mode) && $past(cfg_near_lb)) |-> (cur_mode == LB_NEAR));

    assert_switch_at_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != $past(cur_mode)) |->
        ($past(!mac_txen && !line_rxdv) && !mac_rxdv && !line_txdv));
endmodule

bind phy_loopback_ctrl phy_lb_checker #(.NIB_W(NIB_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode),
    .mac_txd(mac_txd), .mac_txen(mac_txen), .line_rxd(line_rxd), .line_rxdv(line_rxdv),
    .cfg_near_lb(cfg_near_lb), .cfg_col_test(cfg_col_test), .cfg_far_lb(cfg_far_lb),
    .cfg_rmii(cfg_rmii), .mac_rxd(mac_rxd), .mac_rxdv(mac_rxdv), .mac_crs(mac_crs),
    .mac_col(mac_col), .line_txd(line_txd), .line_txdv(line_txdv), .line_tx_on(line_tx_on)
);

// File: tb/phy_loopback_ctrl_test.sv
`timescale 1ns/1ps
module phy_loopback_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] mac_txd = '0, line_rxd = '0;
    logic       mac_txen = 1'b0, line_rxdv = 1'b0;
    logic       cfg_near_lb = 1'b0, cfg_col_test = 1'b0, cfg_far_lb = 1'b0, cfg_rmii = 1'b0;
    logic [3:0] mac_rxd, line_txd;
    logic       mac_rxdv, mac_crs, mac_col, line_txdv, line_tx_on;

    int checks = 0;
    int errors = 0;
    int n = 0;
    int exp_mode = 0;     // 0 normal, 1 near, 2 far
    bit chk_on = 1'b0;
    string tag = "R2";

    logic [3:0] h_txd [4];
    logic       h_txen[4];
    logic [3:0] h_rxd [4];
    logic       h_rxdv[4];

    always #2.5 clk = ~clk;

    phy_loopback_ctrl uut (
        .clk(clk), .rst_n(rst_n), .mac_txd(mac_txd), .mac_txen(mac_txen),
        .line_rxd(line_rxd), .line_rxdv(line_rxdv), .cfg_near_lb(cfg_near_lb),
        .cfg_col_test(cfg_col_test), .cfg_far_lb(cfg_far_lb), .cfg_rmii(cfg_rmii),
        .mac_rxd(mac_rxd), .mac_rxdv(mac_rxdv), .mac_crs(mac_crs), .mac_col(mac_col),
        .line_txd(line_txd), .line_txdv(line_txdv), .line_tx_on(line_tx_on)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h cycle=%0d", req, what, act, exp, n);
        end
    endtask

    // One cycle: check outputs against inputs of earlier cycles, then drive new inputs.
    task automatic step(logic te, logic [3:0] td, logic rv, logic [3:0] rd);
        int a, b;
        @(negedge clk);
        n++;
        a = (n + 2) % 4;
        b = (n + 3) % 4;
        if (chk_on) begin
            case (exp_mode)
                0: begin
                    chk(tag, "line_tx", {line_tx_on, line_txdv, line_txd}, {1'b1, h_txen[a], h_txd[a]});
                    chk(tag, "mac_rx", {mac_crs, mac_rxdv, mac_rxd}, {h_rxdv[a], h_rxdv[a], h_rxd[a]});
                    chk("R3", "mac_col", mac_col, h_txen[a] & h_rxdv[a]);
                end
                1: begin
                    chk(tag, "mac_rx", {mac_crs, mac_rxdv, mac_rxd}, {h_txen[a], h_txen[a], h_txd[a]});
                    chk("R5", "line_tx", {line_tx_on, line_txdv, line_txd}, 0);
                    chk("R6", "mac_col", mac_col, cfg_col_test & h_txen[b]);
                end
                default: begin
                    chk(tag, "line_tx", {line_tx_on, line_txdv, line_txd}, {1'b1, h_rxdv[a], h_rxd[a]});
                    chk("R9", "mac_side", {mac_col, mac_crs, mac_rxdv, mac_rxd}, 0);
                end
            endcase
        end
        mac_txen = te; mac_txd = td; line_rxdv = rv; line_rxd = rd;
        h_txen[n % 4] = te; h_txd[n % 4] = td; h_rxdv[n % 4] = rv; h_rxd[n % 4] = rd;
    endtask

    task automatic set_mode(logic nr, logic ct, logic fr, logic rm, int em, string t);
        chk_on = 1'b0;
        cfg_near_lb = nr; cfg_col_test = ct; cfg_far_lb = fr; cfg_rmii = rm;
        for (int i = 0; i < 4; i++) step(1'b0, 4'h0, 1'b0, 4'h0);
        exp_mode = em;
        tag = t;
        chk_on = 1'b1;
    endtask

    task automatic sweep();
        for (int i = 0; i < 1024; i++)
            step(i[0], i[4:1], i[5], i[9:6] ^ i[4:1]);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            h_txd[i] = '0; h_txen[i] = 1'b0; h_rxd[i] = '0; h_rxdv[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk("R1", "reset_outputs",
            {mac_rxd, mac_rxdv, mac_crs, mac_col, line_txd, line_txdv, line_tx_on}, 1);
        rst_n = 1'b1;
        step(1'b0, 4'h0, 1'b0, 4'h0);
        step(1'b0, 4'h0, 1'b0, 4'h0);
        chk("R1", "after_reset",
            {mac_rxd, mac_rxdv, mac_crs, mac_col, line_txd, line_txdv, line_tx_on}, 1);

        set_mode(1'b0, 1'b0, 1'b0, 1'b0, 0, "R2"); sweep();
        set_mode(1'b1, 1'b0, 1'b0, 1'b0, 1, "R4"); sweep();
        set_mode(1'b1, 1'b1, 1'b0, 1'b0, 1, "R4"); sweep();
        set_mode(1'b0, 1'b0, 1'b1, 1'b1, 2, "R7"); sweep();
        set_mode(1'b0, 1'b1, 1'b1, 1'b0, 0, "R8"); sweep();
        set_mode(1'b1, 1'b0, 1'b1, 1'b1, 1, "R10"); sweep();

        // R11: request change in the middle of a near-end frame
        set_mode(1'b1, 1'b1, 1'b0, 1'b0, 1, "R11");
        for (int i = 0; i < 6; i++) begin
            if (i == 2) begin
                cfg_near_lb = 1'b0;
                cfg_far_lb  = 1'b1;
                cfg_rmii    = 1'b1;
            end
            step(1'b1, 4'(i + 3), 1'b1, 4'(i));
        end
        step(1'b0, 4'h0, 1'b0, 4'h0);
        step(1'b0, 4'h0, 1'b0, 4'h0);
        chk_on = 1'b0;
        for (int i = 0; i < 3; i++) step(1'b0, 4'h0, 1'b0, 4'h0);
        exp_mode = 2;
        chk_on = 1'b1;
        for (int i = 0; i < 8; i++) step(i[0], 4'(i), 1'b1, 4'(15 - i));

        // R11: far frame in progress holds FAR until it ends
        cfg_far_lb = 1'b0;
        for (int i = 0; i < 4; i++) step(1'b1, 4'h9, 1'b1, 4'(i + 8));
        step(1'b0, 4'h0, 1'b0, 4'h0);
        step(1'b0, 4'h0, 1'b0, 4'h0);
        chk_on = 1'b0;
        for (int i = 0; i < 3; i++) step(1'b0, 4'h0, 1'b0, 4'h0);
        exp_mode = 0;
        chk_on = 1'b1;
        for (int i = 0; i < 8; i++) step(1'b1, 4'(i), i[1], 4'(i + 1));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=done", n);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule